// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

The block maps a physical address onto one of a set of DRAM chip-select rows on a single memory channel. Software loads one 8-bit boundary value for each row through a small write port. Each boundary is the cumulative upper limit of its row, counted in 8 MB units. The row's lower edge is the upper limit of the row before it. Row 0 begins at address zero.

From these values the block derives the base and limit of every row and flags the rows that hold no memory. A row is empty when its limit does not exceed its base. A boundary of zero that follows a nonzero limit stands for the 2 GB top of the address space. The address decode is purely combinational. For any address it gives a hit flag, the index of the matching row and a one-hot row-select vector. Addresses above the populated memory select no row.

Top module: `dram_row_decoder`

## Requirements
- R1: A write with `wr_en_i` high stores `wr_data_i` as the boundary of row `wr_idx_i` at the next rising clock edge. The boundaries of all other rows keep their values.
- R2: A row's limit is its boundary value shifted left by 23 bits (8 MB units). Row 0 has base 0. Row k has base equal to the limit of row k-1. Row k's base and limit appear on `row_base_o` and `row_limit_o` at bits [32k+31:32k].
- R3: A row is empty when its limit is less than or equal to its base. Bit k of `row_empty_o` is 1 for an empty row k, and an empty row is never selected.
- R4: A boundary value of 0 in a row whose base is nonzero gives that row a limit of 0x8000_0000. A zero boundary in row 0, or in a row whose base is 0, gives limit 0.
- R5: When a non-empty row k has base <= `addr_i` < limit, `hit_o` is 1, `row_idx_o` equals k, and `row_sel_o` has only bit k set.
- R6: When no non-empty row holds the address, `hit_o` is 0, `row_sel_o` is all zero and `row_idx_o` is 0. This covers any address at or above the highest populated limit.
- R7: When the ranges of several non-empty rows hold the address (possible only with decreasing boundaries), the lowest-numbered of those rows is selected.
- R8: While reset is asserted and after it, until the first write, every boundary is 0. Every row is then empty with base and limit 0, and no address hits.
- R9: The decode follows `addr_i` combinationally: a change of address shows on `hit_o`, `row_idx_o` and `row_sel_o` without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the boundary registers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Boundary register write strobe |
| wr_idx_i | input | 3 | Row whose boundary is written |
| wr_data_i | input | 8 | Boundary value in 8 MB units |
| addr_i | input | 32 | Physical address to decode |
| hit_o | output | 1 | Address falls in a populated row |
| row_idx_o | output | 3 | Index of the selected row |
| row_sel_o | output | 8 | One-hot row select |
| row_empty_o | output | 8 | Per-row empty flag |
| row_base_o | output | 256 | Packed base address of each row |
| row_limit_o | output | 256 | Packed exclusive upper limit of each row |

## Verification
The bench builds the decoder with its default parameters: eight rows, 8-bit boundaries, a 23-bit unit shift and a 32-bit address. With these values an ordinary boundary reaches at most 0x7F80_0000, so the 2 GB top can only come from the zero-after-nonzero rule, and the bench exercises that rule directly. It also places addresses on both sides of each row edge, and it checks the address 0x8000_0000 just past the top. A decreasing boundary sequence produces overlapping ranges, which brings the lowest-index priority within reach.

// File: rtl/dram_row_pkg.sv
package dram_row_pkg;
  parameter int unsigned DEF_ROWS       = 8;
  parameter int unsigned DEF_BND_W      = 8;
  parameter int unsigned DEF_UNIT_SHIFT = 23;
  parameter int unsigned DEF_ADDR_W     = 32;
endpackage

// File: rtl/row_bound_regs.sv
module row_bound_regs #(
  parameter int unsigned NUM_ROWS = dram_row_pkg::DEF_ROWS,
  parameter int unsigned BND_W    = dram_row_pkg::DEF_BND_W,
  localparam int unsigned IDX_W   = $clog2(NUM_ROWS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [BND_W-1:0]          wr_data_i,
  output logic [NUM_ROWS*BND_W-1:0] bnd_o
);
  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_reg
    logic [BND_W-1:0] bnd_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bnd_q <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(i))) bnd_q <= wr_data_i;
    end
    assign bnd_o[i*BND_W +: BND_W] = bnd_q;
  end
endmodule

// File: rtl/row_limit_calc.sv
module row_limit_calc #(
  parameter int unsigned NUM_ROWS   = dram_row_pkg::DEF_ROWS,
  parameter int unsigned BND_W      = dram_row_pkg::DEF_BND_W,
  parameter int unsigned UNIT_SHIFT = dram_row_pkg::DEF_UNIT_SHIFT,
  parameter int unsigned ADDR_W     = dram_row_pkg::DEF_ADDR_W
) (
  input  logic [NUM_ROWS*BND_W-1:0]  bnd_i,
  output logic [NUM_ROWS*ADDR_W-1:0] base_o,
  output logic [NUM_ROWS*ADDR_W-1:0] limit_o,
  output logic [NUM_ROWS-1:0]        empty_o
);
  localparam int unsigned TOP_BIT = BND_W + UNIT_SHIFT;
  localparam logic [ADDR_W-1:0] TOP_LIMIT = ADDR_W'(1) << TOP_BIT;

  logic [ADDR_W-1:0] lim [NUM_ROWS];

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] prev;
    assign raw = ADDR_W'(bnd_i[i*BND_W +: BND_W]) << UNIT_SHIFT;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_next
      assign prev = lim[i-1];
    end
    // zero after a nonzero limit stands for the full top of memory
    assign lim[i] = ((prev != '0) && (raw == '0)) ? TOP_LIMIT : raw;
    assign base_o[i*ADDR_W +: ADDR_W]  = prev;
    assign limit_o[i*ADDR_W +: ADDR_W] = lim[i];
    assign empty_o[i] = (lim[i] <= prev);
  end
endmodule

// File: rtl/row_match.sv
module row_match #(
  parameter int unsigned NUM_ROWS = dram_row_pkg::DEF_ROWS,
  parameter int unsigned ADDR_W   = dram_row_pkg::DEF_ADDR_W,
  localparam int unsigned IDX_W   = $clog2(NUM_ROWS)
) (
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [NUM_ROWS*ADDR_W-1:0] base_i,
  input  logic [NUM_ROWS*ADDR_W-1:0] limit_i,
  input  logic [NUM_ROWS-1:0]        empty_i,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [NUM_ROWS-1:0]        sel_o
);
  logic [NUM_ROWS-1:0] in_rng;

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_cmp
    assign in_rng[i] = !empty_i[i]
                     && (addr_i >= base_i[i*ADDR_W +: ADDR_W])
                     && (addr_i <  limit_i[i*ADDR_W +: ADDR_W]);
  end

  // isolate the lowest set bit
  assign sel_o = in_rng & (~in_rng + NUM_ROWS'(1));
  assign hit_o = |in_rng;

  always_comb begin
    idx_o = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (in_rng[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder #(
  parameter int unsigned NUM_ROWS   = dram_row_pkg::DEF_ROWS,
  parameter int unsigned BND_W      = dram_row_pkg::DEF_BND_W,
  parameter int unsigned UNIT_SHIFT = dram_row_pkg::DEF_UNIT_SHIFT,
  parameter int unsigned ADDR_W     = dram_row_pkg::DEF_ADDR_W,
  localparam int unsigned IDX_W     = $clog2(NUM_ROWS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [BND_W-1:0]           wr_data_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic                       hit_o,
  output logic [IDX_W-1:0]           row_idx_o,
  output logic [NUM_ROWS-1:0]        row_sel_o,
  output logic [NUM_ROWS-1:0]        row_empty_o,
  output logic [NUM_ROWS*ADDR_W-1:0] row_base_o,
  output logic [NUM_ROWS*ADDR_W-1:0] row_limit_o
);
  logic [NUM_ROWS*BND_W-1:0] bnd;

  row_bound_regs #(.NUM_ROWS(NUM_ROWS), .BND_W(BND_W)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .bnd_o     (bnd)
  );

  row_limit_calc #(
    .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .UNIT_SHIFT(UNIT_SHIFT), .ADDR_W(ADDR_W)
  ) i_calc (
    .bnd_i   (bnd),
    .base_o  (row_base_o),
    .limit_o (row_limit_o),
    .empty_o (row_empty_o)
  );

  row_match #(.NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W)) i_match (
    .addr_i  (addr_i),
    .base_i  (row_base_o),
    .limit_i (row_limit_o),
    .empty_i (row_empty_o),
    .hit_o   (hit_o),
    .idx_o   (row_idx_o),
    .sel_o   (row_sel_o)
  );
endmodule

// File: rtl/dram_row_decoder_chk.sv
module dram_row_decoder_chk #(
  parameter int unsigned NUM_ROWS   = 8,
  parameter int unsigned BND_W      = 8,
  parameter int unsigned UNIT_SHIFT = 23,
  parameter int unsigned ADDR_W     = 32,
  localparam int unsigned IDX_W     = $clog2(NUM_ROWS)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_en_i,
  input logic [IDX_W-1:0]           wr_idx_i,
  input logic [BND_W-1:0]           wr_data_i,
  input logic [ADDR_W-1:0]          addr_i,
  input logic                       hit_o,
  input logic [IDX_W-1:0]           row_idx_o,
  input logic [NUM_ROWS-1:0]        row_sel_o,
  input logic [NUM_ROWS-1:0]        row_empty_o,
  input logic [NUM_ROWS*ADDR_W-1:0] row_base_o,
  input logic [NUM_ROWS*ADDR_W-1:0] row_limit_o
);
  logic [ADDR_W-1:0] sel_base, sel_lim;
  assign sel_base = row_base_o[row_idx_o*ADDR_W +: ADDR_W];
  assign sel_lim  = row_limit_o[row_idx_o*ADDR_W +: ADDR_W];

  a_r5_onehot_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_sel_o));

  a_r6_hit_matches_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (row_sel_o != '0));

  a_r5_hit_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (addr_i >= sel_base && addr_i < sel_lim && row_sel_o[row_idx_o]));

  a_r3_empty_unselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_sel_o & row_empty_o) == '0);

  a_r1_row0_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == '0) |=>
      row_limit_o[ADDR_W-1:0] == (ADDR_W'($past(wr_data_i)) << UNIT_SHIFT));

  a_r2_row0_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_base_o[ADDR_W-1:0] == '0);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r8_reset_empty: assert (row_empty_o == '1 && !hit_o);
    end
  end
endmodule

bind dram_row_decoder dram_row_decoder_chk #(
  .NUM_ROWS(NUM_ROWS), .BND_W(BND_W), .UNIT_SHIFT(UNIT_SHIFT), .ADDR_W(ADDR_W)
) i_chk (.*);

// File: tb/test_dram_row_decoder.sv
`timescale 1ns/1ps
module test_dram_row_decoder;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0;
  logic [2:0]   wr_idx_i = '0;
  logic [7:0]   wr_data_i = '0;
  logic [31:0]  addr_i = '0;
  logic         hit_o;
  logic [2:0]   row_idx_o;
  logic [7:0]   row_sel_o;
  logic [7:0]   row_empty_o;
  logic [255:0] row_base_o;
  logic [255:0] row_limit_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  dram_row_decoder i_dram_row_decoder (.*);

  function automatic logic [31:0] lim(int k);
    return row_limit_o[k*32 +: 32];
  endfunction
  function automatic logic [31:0] bas(int k);
    return row_base_o[k*32 +: 32];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(int k, logic [7:0] v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_idx_i = 3'(k); wr_data_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic load(logic [7:0] b [8]);
    for (int k = 0; k < 8; k++) wr(k, b[k]);
  endtask

  task automatic look(string req, logic [31:0] a, logic h, logic [2:0] idx, logic [7:0] sel);
    addr_i = a;
    #1;
    chk(req, "hit", 32'(hit_o), 32'(h));
    chk(req, "idx", 32'(row_idx_o), 32'(idx));
    chk(req, "sel", 32'(row_sel_o), 32'(sel));
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    chk("R8", "empty in reset", 32'(row_empty_o), 32'hFF);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8", "empty after reset", 32'(row_empty_o), 32'hFF);
    chk("R8", "limit7", lim(7), 32'h0);
    look("R8", 32'h0, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] b [8] = '{8'd1, 8'd2, 8'd2, 8'd4, 8'd4, 8'd4, 8'd4, 8'd4};
    load(b);
    chk("R2", "limit0", lim(0), 32'h0080_0000);
    chk("R2", "base1", bas(1), 32'h0080_0000);
    chk("R2", "limit3", lim(3), 32'h0200_0000);
    chk("R3", "empty map", 32'(row_empty_o), 32'hF4);
    look("R5", 32'h0000_0000, 1'b1, 3'd0, 8'h01);
    look("R5", 32'h007F_FFFF, 1'b1, 3'd0, 8'h01);
    look("R5", 32'h0080_0000, 1'b1, 3'd1, 8'h02);
    look("R3", 32'h0100_0000, 1'b1, 3'd3, 8'h08);
    look("R9", 32'h01FF_FFFF, 1'b1, 3'd3, 8'h08);
    look("R6", 32'h0200_0000, 1'b0, 3'd0, 8'h00);
    look("R6", 32'hFFFF_FFFF, 1'b0, 3'd0, 8'h00);
    wr(5, 8'd6);
    chk("R1", "row5 written", lim(5), 32'h0300_0000);
    chk("R1", "row4 untouched", lim(4), 32'h0200_0000);
    chk("R1", "row6 untouched", lim(6), 32'h0200_0000);
    look("R1", 32'h0280_0000, 1'b1, 3'd5, 8'h20);
  endtask

  task automatic t_top();
    logic [7:0] b [8] = '{8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    load(b);
    chk("R4", "limit1 top", lim(1), 32'h8000_0000);
    chk("R4", "limit2 top", lim(2), 32'h8000_0000);
    chk("R4", "empty map", 32'(row_empty_o), 32'hFC);
    look("R4", 32'h7FFF_FFFF, 1'b1, 3'd1, 8'h02);
    look("R4", 32'h0800_0000, 1'b1, 3'd1, 8'h02);
    look("R6", 32'h8000_0000, 1'b0, 3'd0, 8'h00);
    wr(0, 8'h00);
    chk("R4", "row0 zero", lim(0), 32'h0);
    chk("R4", "row1 zero base", lim(1), 32'h0);
    look("R6", 32'h0000_1000, 1'b0, 3'd0, 8'h00);
  endtask

  task automatic t_prio();
    logic [7:0] b [8] = '{8'd4, 8'd2, 8'd3, 8'd3, 8'd3, 8'd3, 8'd3, 8'd3};
    load(b);
    chk("R3", "decreasing empty", 32'(row_empty_o), 32'hFA);
    look("R7", 32'h0140_0000, 1'b1, 3'd0, 8'h01);
    look("R7", 32'h01F0_0000, 1'b1, 3'd0, 8'h01);
    look("R6", 32'h0200_0000, 1'b0, 3'd0, 8'h00);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_top();
    t_prio();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule